// File: doc/BRIEF.md
# Daisy-Chain SPI Command Sequencer

This block is an SPI master for a string of identical slaves. Each slave's data output feeds the data input of the next one, and all slaves share one chip select and one serial clock. The host presents one 16-bit command for every slave on `cmd_words` and raises `start_req` with `rd_mode` set for a read or cleared for a write. The engine then shifts the whole set out in one frame, so that each command ends up in its own slave when chip select rises. Because data travels from slave 0 towards slave N-1, the command for the far end of the chain goes out first.

A write transaction is a single frame. A read transaction is two frames. The first frame carries the read commands. The second frame carries only NOP words (16'h0000) and collects the replies. Each reply is filed under the index of the slave that sent it and is checked for a well-formed header.

The command side behaves as a valid/ready pair whose ready is `!busy`. A request is taken only in a cycle where `busy` is low. A request made while `busy` is high is dropped, not queued. The response side has no back-pressure. `rsp_words` and `rsp_err` are updated at the end of each read and hold until the next read completes.

Top module: `dchain_spi_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0 and `rsp_err` is 0.
- R2: Every frame holds exactly N_DEV*16 rising edges of `spi_sck` between the fall of `spi_cs_n` and its rise.
- R3: In a command frame, MOSI carries `cmd_words` MSB first. Word N_DEV-1 (bits [16*N_DEV-1 -: 16]) goes out first and word 0 goes out last, so word k lands in slave k.
- R4: A write (`rd_mode`=0) is exactly one frame. In the bench's slave model, opcode 010 in bits [15:13] writes bits [7:0] to the address in bits [12:8].
- R5: A read (`rd_mode`=1) is exactly two frames. The first carries the commands. During the second, MOSI stays 0 (NOP word 16'h0000). In the bench's slave model, opcode 001 is a read.
- R6: Between the two frames of a read, `spi_cs_n` stays high for at least 2*SCK_DIV clock cycles, which is two SCK periods.
- R7: MOSI changes only on a falling SCK edge and is stable while SCK is high. MISO is sampled on the rising edge.
- R8: The reply from slave k is stored in `rsp_words[16*k +: 16]`, and the first reply word received belongs to slave N_DEV-1.
- R9: `rsp_err` is set after a read when any reply has bits [15:13] other than 111 or has bits [12:8] that differ from bits [12:8] of the command sent to that slave. It is 0 otherwise, and it is cleared when a request is accepted.
- R10: A `start_req` that arrives while `busy` is high has no effect.
- R11: `spi_sck` is low whenever `spi_cs_n` is high.
- R12: `busy` rises when a request is accepted and falls in the same cycle that `spi_cs_n` rises at the end of the last frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request a transaction (taken when busy is low) |
| rd_mode | input | 1 | 1 = read transaction, 0 = write |
| cmd_words | input | 16*N_DEV | One command word per slave, word k for slave k |
| busy | output | 1 | Transaction in progress |
| rsp_words | output | 16*N_DEV | Read replies filed by slave index |
| rsp_err | output | 1 | Malformed or mismatched reply seen in last read |
| spi_cs_n | output | 1 | Shared chip select, active low |
| spi_sck | output | 1 | Shared serial clock |
| spi_mosi | output | 1 | Serial data to slave 0 |
| spi_miso | input | 1 | Serial data from slave N_DEV-1 |

## Verification
Two things can meet in one cycle: the end of a transaction, where `busy` falls as chip select rises, and a new start request. The bench holds `start_req` high with a second command set across the end of a write. The request must be refused while `busy` is still high and accepted on the very next cycle. This shows up as `busy` being low for exactly one sampled cycle, with both command sets applied in the slaves in order. A separate case pulses a read request in the middle of a write and checks at the slaves and frame counters that nothing changed.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_LSB = 8;
  localparam int ADDR_W = 5;
  localparam logic [2:0] HDR_TAG = 3'b111;
  localparam logic [WORD_W-1:0] NOP_WORD = 16'h0000;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FRAME1,
    SEQ_GAP,
    SEQ_FRAME2
  } seq_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_SETUP,
    FR_HIGH,
    FR_LOW,
    FR_HOLD
  } frame_e;
endpackage

// File: rtl/dchain_tick.sv
module dchain_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/dchain_frame.sv
module dchain_frame
  import dchain_pkg::*;
#(
  parameter int BITS = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] tx,
  input  logic            tick,
  input  logic            miso,
  output logic            cs_n,
  output logic            sck,
  output logic            mosi,
  output logic            active,
  output logic            done,
  output logic [BITS-1:0] rx
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);

  frame_e          state;
  logic [BITS-1:0] sh_tx;
  logic [BITS-1:0] sh_rx;
  logic [CW-1:0]   nbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FR_IDLE;
      cs_n  <= 1'b1;
      sck   <= 1'b0;
      sh_tx <= '0;
      sh_rx <= '0;
      nbit  <= '0;
    end else if (load && state == FR_IDLE) begin
      state <= FR_SETUP;
      cs_n  <= 1'b0;
      sck   <= 1'b0;
      sh_tx <= tx;
      nbit  <= '0;
    end else if (tick) begin
      unique case (state)
        FR_SETUP, FR_LOW: begin
          sck   <= 1'b1;
          sh_rx <= {sh_rx[BITS-2:0], miso};
          state <= FR_HIGH;
        end
        FR_HIGH: begin
          sck <= 1'b0;
          if (nbit == LAST_BIT) begin
            state <= FR_HOLD;
          end else begin
            sh_tx <= {sh_tx[BITS-2:0], 1'b0};
            nbit  <= nbit + 1'b1;
            state <= FR_LOW;
          end
        end
        FR_HOLD: begin
          cs_n  <= 1'b1;
          state <= FR_IDLE;
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  assign mosi   = sh_tx[BITS-1];
  assign active = (state != FR_IDLE);
  assign done   = (state == FR_HOLD) && tick;
  assign rx     = sh_rx;

  // Checker counter: rising SCK edges seen inside the current frame
  logic [CW-1:0] edge_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                edge_cnt <= '0;
    else if (cs_n)             edge_cnt <= '0;
    else if (sck && !$past(sck)) edge_cnt <= edge_cnt + 1'b1;
  end

  p_edge_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> edge_cnt == CW'(BITS));

  p_mosi_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  p_sck_parked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
endmodule

// File: rtl/dchain_check.sv
module dchain_check
  import dchain_pkg::*;
#(
  parameter int N_DEV = 3
) (
  input  logic [N_DEV*WORD_W-1:0] rsp,
  input  logic [N_DEV*WORD_W-1:0] req,
  output logic                    bad
);
  logic [N_DEV-1:0] dev_bad;

  for (genvar k = 0; k < N_DEV; k++) begin : g_dev
    logic [WORD_W-1:0] r_word;
    logic [WORD_W-1:0] q_word;
    assign r_word = rsp[k*WORD_W +: WORD_W];
    assign q_word = req[k*WORD_W +: WORD_W];
    assign dev_bad[k] = (r_word[WORD_W-1 -: 3] != HDR_TAG) ||
                        (r_word[ADDR_LSB +: ADDR_W] != q_word[ADDR_LSB +: ADDR_W]);
  end

  assign bad = |dev_bad;
endmodule

// File: rtl/dchain_spi_master.sv
module dchain_spi_master
  import dchain_pkg::*;
#(
  parameter int N_DEV   = 3,
  parameter int SCK_DIV = 4,
  parameter int GAP_SCK = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_req,
  input  logic                    rd_mode,
  input  logic [N_DEV*16-1:0]     cmd_words,
  output logic                    busy,
  output logic [N_DEV*16-1:0]     rsp_words,
  output logic                    rsp_err,
  output logic                    spi_cs_n,
  output logic                    spi_sck,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  localparam int BITS   = N_DEV * WORD_W;
  localparam int HALF   = SCK_DIV / 2;
  localparam int GAP_HV = 2 * GAP_SCK;
  localparam int GW     = $clog2(GAP_HV + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_HV - 1);
  localparam int MIN_GAP = 2 * SCK_DIV;
  localparam int MW = $clog2(MIN_GAP + 2);

  seq_e            st;
  logic            mode_q;
  logic [BITS-1:0] cmd_q;
  logic [GW-1:0]   gap_cnt;
  logic            tick;
  logic            f_load;
  logic            f_active;
  logic            f_done;
  logic [BITS-1:0] f_tx;
  logic [BITS-1:0] f_rx;
  logic            rsp_bad;
  logic            accept;

  assign accept = (st == SEQ_IDLE) && start_req;
  assign f_load = accept || ((st == SEQ_GAP) && tick && gap_cnt == GAP_LAST);
  assign f_tx   = (st == SEQ_IDLE) ? cmd_words : {N_DEV{NOP_WORD}};

  dchain_tick #(.HALF(HALF)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (f_active || st == SEQ_GAP),
    .tick (tick)
  );

  dchain_frame #(.BITS(BITS)) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (f_load),
    .tx    (f_tx),
    .tick  (tick),
    .miso  (spi_miso),
    .cs_n  (spi_cs_n),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .active(f_active),
    .done  (f_done),
    .rx    (f_rx)
  );

  dchain_check #(.N_DEV(N_DEV)) u_check (
    .rsp(f_rx),
    .req(cmd_q),
    .bad(rsp_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SEQ_IDLE;
      mode_q    <= 1'b0;
      cmd_q     <= '0;
      gap_cnt   <= '0;
      busy      <= 1'b0;
      rsp_words <= '0;
      rsp_err   <= 1'b0;
    end else begin
      unique case (st)
        SEQ_IDLE: if (start_req) begin
          mode_q  <= rd_mode;
          cmd_q   <= cmd_words;
          busy    <= 1'b1;
          rsp_err <= 1'b0;
          st      <= SEQ_FRAME1;
        end
        SEQ_FRAME1: if (f_done) begin
          if (mode_q) begin
            gap_cnt <= '0;
            st      <= SEQ_GAP;
          end else begin
            busy <= 1'b0;
            st   <= SEQ_IDLE;
          end
        end
        SEQ_GAP: if (tick) begin
          if (gap_cnt == GAP_LAST) st <= SEQ_FRAME2;
          else                     gap_cnt <= gap_cnt + 1'b1;
        end
        SEQ_FRAME2: if (f_done) begin
          rsp_words <= f_rx;
          rsp_err   <= rsp_bad;
          busy      <= 1'b0;
          st        <= SEQ_IDLE;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  // Checker counter: cycles with CS high inside a busy transaction
  logic [MW-1:0] hi_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_cyc <= '0;
    else if (!busy || !spi_cs_n) hi_cyc <= '0;
    else if (hi_cyc != MW'(MIN_GAP + 1)) hi_cyc <= hi_cyc + 1'b1;
  end

  p_gap_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_cs_n) && $past(busy)) |-> hi_cyc >= MW'(MIN_GAP));

  p_nop_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_FRAME2 && !spi_cs_n) |-> !spi_mosi);

  p_idle_cs_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  p_busy_until_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !spi_cs_n) |=> busy || spi_cs_n);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> $stable(mode_q) && $stable(cmd_q));

  p_resp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SEQ_FRAME2) |=> $stable(rsp_words));

  p_write_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> !rsp_err);
endmodule

// File: tb/tb_dchain_spi_master.sv
module tb_dchain_spi_master;
  localparam int N = 3;
  localparam int SCK_DIV = 4;
  localparam int BITS = N * 16;
  localparam logic [2:0] OP_WR = 3'b010;
  localparam logic [2:0] OP_RD = 3'b001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic rd_mode = 1'b0;
  logic [BITS-1:0] cmd_words = '0;
  logic busy, rsp_err, spi_cs_n, spi_sck, spi_mosi, spi_miso;
  logic [BITS-1:0] rsp_words;

  always #5 clk = ~clk;

  dchain_spi_master #(.N_DEV(N), .SCK_DIV(SCK_DIV), .GAP_SCK(2)) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .rd_mode(rd_mode),
    .cmd_words(cmd_words), .busy(busy), .rsp_words(rsp_words), .rsp_err(rsp_err),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- slave chain model ----------------
  logic [15:0] s_sr [N];
  logic        s_in [N];
  logic [7:0]  s_mem [N][32];
  logic [7:0]  exp_mem [N][32];
  int bad_dev = -1;
  int bad_kind = 0;

  assign spi_miso = s_sr[N-1][15];

  initial begin
    for (int k = 0; k < N; k++) begin
      s_sr[k] = '0;
      s_in[k] = 1'b0;
      for (int a = 0; a < 32; a++) begin
        s_mem[k][a] = '0;
        exp_mem[k][a] = '0;
      end
    end
  end

  always @(posedge spi_sck)
    for (int k = 0; k < N; k++) s_in[k] <= (k == 0) ? spi_mosi : s_sr[k-1][15];

  always @(negedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n === 1'b1) begin
      for (int k = 0; k < N; k++) begin
        logic [2:0] op;
        logic [4:0] ad;
        logic [15:0] nxt;
        op = s_sr[k][15:13];
        ad = s_sr[k][12:8];
        nxt = 16'h0000;
        if (op == OP_WR) s_mem[k][ad] = s_sr[k][7:0];
        else if (op == OP_RD) begin
          nxt = {3'b111, ad, s_mem[k][ad]};
          if (k == bad_dev && bad_kind == 0) nxt[15:13] = 3'b110;
          if (k == bad_dev && bad_kind == 1) nxt[12:8] = ad ^ 5'd1;
        end
        s_sr[k] = nxt;
      end
    end else if (spi_cs_n === 1'b0) begin
      for (int k = 0; k < N; k++) s_sr[k] <= {s_sr[k][14:0], s_in[k]};
    end
  end

  // ---------------- frame monitor ----------------
  bit mon_on = 1'b0;
  bit cur_read = 1'b0;
  int n_fr = 0;
  int cur_edges = 0;
  logic [BITS-1:0] cur_log = '0;
  logic [BITS-1:0] fr_log [2];
  int fr_edge [2];
  realtime t_up = 0;
  realtime gap_ns = 0;

  always @(negedge spi_cs_n) if (mon_on) begin
    if (n_fr > 0) gap_ns = $realtime - t_up;
    cur_log = '0;
    cur_edges = 0;
  end

  always @(posedge spi_sck) if (mon_on) begin
    cur_log = {cur_log[BITS-2:0], spi_mosi};
    cur_edges++;
  end

  always @(posedge spi_cs_n) if (mon_on) begin
    if (n_fr < 2) begin
      fr_log[n_fr] = cur_log;
      fr_edge[n_fr] = cur_edges;
    end
    n_fr++;
    t_up = $realtime;
    #1;
    chk(busy == ((cur_read && n_fr == 1) ? 1'b1 : 1'b0), "R12 busy at CS rise", busy,
        (cur_read && n_fr == 1) ? 1 : 0);
  end

  // ---------------- helpers ----------------
  function automatic logic [15:0] mk(input logic [2:0] op, input int a, input int d);
    return {op, 5'(a), 8'(d)};
  endfunction

  task automatic launch(input bit rd, input logic [BITS-1:0] w);
    @(negedge clk);
    n_fr = 0;
    cur_read = rd;
    cmd_words = w;
    rd_mode = rd;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_write(input logic [BITS-1:0] w);
    chk(n_fr == 1, "R4 one frame on write", n_fr, 1);
    chk(fr_edge[0] == BITS, "R2 SCK edges in frame", fr_edge[0], BITS);
    chk(fr_log[0] == w, "R3 MOSI order", fr_log[0], w);
    for (int k = 0; k < N; k++) begin
      logic [15:0] wd;
      wd = w[16*k +: 16];
      exp_mem[k][wd[12:8]] = wd[7:0];
      chk(s_mem[k][wd[12:8]] == wd[7:0], "R3 word k reaches slave k", s_mem[k][wd[12:8]], wd[7:0]);
    end
  endtask

  task automatic do_write(input logic [BITS-1:0] w);
    launch(1'b0, w);
    wait_idle();
    check_write(w);
  endtask

  task automatic do_read(input logic [BITS-1:0] w, input bit exp_err);
    launch(1'b1, w);
    wait_idle();
    chk(n_fr == 2, "R5 two frames on read", n_fr, 2);
    chk(fr_log[0] == w, "R3 read commands order", fr_log[0], w);
    chk(fr_log[1] == '0, "R5 NOP frame", fr_log[1], 0);
    chk(fr_edge[1] == BITS, "R2 SCK edges NOP frame", fr_edge[1], BITS);
    chk(gap_ns >= 2 * SCK_DIV * 10, "R6 CS gap ns", 64'(int'(gap_ns)), 2 * SCK_DIV * 10);
    chk(rsp_err == exp_err, "R9 error flag", rsp_err, exp_err);
    if (!exp_err)
      for (int k = 0; k < N; k++) begin
        logic [4:0] ad;
        ad = w[16*k + 8 +: 5];
        chk(rsp_words[16*k +: 16] == {3'b111, ad, exp_mem[k][ad]}, "R8 reply by index",
            rsp_words[16*k +: 16], {3'b111, ad, exp_mem[k][ad]});
      end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [BITS-1:0] wa, wb, rr;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 reset pins", {spi_cs_n, spi_sck}, 2'b10);
    chk(busy == 1'b0 && rsp_err == 1'b0, "R1 reset status", {busy, rsp_err}, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", {spi_cs_n, busy}, 2'b10);

    // Sweep of address/data patterns: write then read back
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < N; k++) begin
        wa[16*k +: 16] = mk(OP_WR, (r*11 + k*7 + 3) % 32, (r*53 + k*29 + 17) & 255);
        rr[16*k +: 16] = mk(OP_RD, (r*11 + k*7 + 3) % 32, 0);
      end
      do_write(wa);
      do_read(rr, 1'b0);
    end

    // R10: request during a write is ignored
    for (int k = 0; k < N; k++) begin
      wa[16*k +: 16] = mk(OP_WR, 20 + k, 8'h5A + k);
      wb[16*k +: 16] = mk(OP_WR, 28 + k, 8'hEE);
    end
    launch(1'b0, wa);
    repeat (30) @(negedge clk);
    cmd_words = wb;
    rd_mode = 1'b1;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    cmd_words = wa;
    wait_idle();
    check_write(wa);
    for (int k = 0; k < N; k++)
      chk(s_mem[k][28 + k] == exp_mem[k][28 + k], "R10 ignored request left slave untouched",
          s_mem[k][28 + k], exp_mem[k][28 + k]);
    repeat (5) @(negedge clk);
    chk(n_fr == 1 && busy == 1'b0, "R10 no extra frame", n_fr, 1);

    // Completion and new request in the same cycle: start held across the end
    begin
      int lows;
      for (int k = 0; k < N; k++) begin
        wa[16*k +: 16] = mk(OP_WR, 4 + k, 8'h31 + k);
        wb[16*k +: 16] = mk(OP_WR, 9 + k, 8'hC0 + k);
      end
      launch(1'b0, wa);
      cmd_words = wb;
      start_req = 1'b1;
      wait_idle();
      lows = 0;
      while (!busy && lows < 10) begin
        lows++;
        @(negedge clk);
      end
      start_req = 1'b0;
      chk(lows == 1, "R12 single idle cycle between back-to-back", lows, 1);
      wait_idle();
      for (int k = 0; k < N; k++) begin
        exp_mem[k][4 + k] = 8'h31 + 8'(k);
        exp_mem[k][9 + k] = 8'hC0 + 8'(k);
        chk(s_mem[k][4 + k] == exp_mem[k][4 + k], "R10 first set applied", s_mem[k][4 + k], exp_mem[k][4 + k]);
        chk(s_mem[k][9 + k] == exp_mem[k][9 + k], "R10 second set applied", s_mem[k][9 + k], exp_mem[k][9 + k]);
      end
    end

    // R9: corrupted header and mismatched address on each slave in turn
    for (int k = 0; k < N; k++) rr[16*k +: 16] = mk(OP_RD, 4 + k, 0);
    for (int d = 0; d < N; d++)
      for (int kind = 0; kind < 2; kind++) begin
        bad_dev = d;
        bad_kind = kind;
        do_read(rr, 1'b1);
      end
    bad_dev = -1;
    do_read(rr, 1'b0);

    // R9: error cleared on next accepted request (a write)
    do_write(wa);
    chk(rsp_err == 1'b0, "R9 cleared by write", rsp_err, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule